// File: doc/BRIEF.md
# Alternating-Polarity Parallel Prefix Adder

This block is a purely combinational binary adder of parameterised width, 64 bits by default. It takes two unsigned operands and produces their sum and a carry-out. It has no carry-in. Internally it forms an inverted generate/propagate pair for each bit. A sparse prefix tree of inverting combine cells then resolves every carry. A final stage forms the sum bits from the inverted propagate and each carry, which arrives in either true or complemented form.

Every level of the prefix tree is built from inverting cells, so the polarity of the stored group signals flips from one level to the next. Odd levels produce true-form outputs from complemented inputs, and even levels do the opposite. A correction is inserted only where a cell reads a value that was last written at a level of its own parity. The correction models a pair of inverters as one polarity flip, and its position is decided when the design is elaborated. The last cell in each column computes only the group generate, which is that column's carry.

The block sits on the critical arithmetic path of an ALU or a multiplier's final adder. The width may be any power of two from 2 upward.

Top module: `apPrefixAdder`

## Requirements
- R1: For every operand pair, `sumOut` equals the low WIDTH bits of the arithmetic sum `opA + opB`.
- R2: `carryOut` equals bit WIDTH of the (WIDTH+1)-bit sum `opA + opB`; with no carry-in, 0 + 0 gives sum 0 and carry-out 0.
- R3: Sum bit 0 equals `opA[0] XOR opB[0]` for every operand pair, because the carry into bit 0 is 0.
- R4: An all-ones operand plus 1, in either operand order, carries through every bit: sum 0, carry-out 1.
- R5: All-ones plus all-ones gives a sum of all ones except bit 0, which is 0, and a carry-out of 1.
- R6: An operand plus its bitwise complement gives a sum of all ones and a carry-out of 0.
- R7: Zero plus any operand returns that operand unchanged, with a carry-out of 0.
- R8: The same RTL is exact at WIDTH 32 and at WIDTH 4; at WIDTH 4 it is exact for all 256 operand pairs.
- R9: A carry generated at any bit k, or rippled from bit 0 up to bit k, appears at sum bit k+1, or at `carryOut` when k is the top bit. Each internal carry obeys the ripple recurrence c[k] = a[k]b[k] | (a[k]^b[k])c[k-1].
- R10: The alternating operands 0x55..55 and 0xAA..AA sum to all ones; 0x55..55 + 0x55..55 gives 0xAA..AA with carry-out 0; 0xAA..AA + 0xAA..AA gives 0x55..54 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| sumOut | output | WIDTH | Low WIDTH bits of opA + opB |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
A misplaced polarity correction or a wrongly typed level cell inverts a group generate. That error shows at once, in the same evaluation, as flipped sum bits above the affected column. It only shows for operand patterns that make that group's generate or propagate matter. The bench therefore walks single-bit generates and carry ripples of every length across the width, and it sweeps a 4-bit build exhaustively so that every cell configuration sees every input. Bound checks compare each internal true-form carry with the ripple recurrence, so a fault in an interior column is caught even when higher bits happen to mask it.

// File: rtl/apAdderPkg.sv
package apAdderPkg;

  // number of prefix levels in the sparse tree: up-sweep then down-sweep
  function automatic int levelCount(input int logW);
    return (logW < 1) ? 0 : 2 * logW - 1;
  endfunction

  // distance from a cell's own column to its lower-order partner column
  function automatic int spanOf(input int lvl, input int logW);
    int d;
    d = (lvl <= logW) ? lvl : 2 * logW - lvl;
    return 1 << (d - 1);
  endfunction

  // does level lvl hold a combine cell in column col
  function automatic bit isCell(input int lvl, input int col, input int logW);
    int d;
    if (lvl <= logW) begin
      d = lvl;
      return ((col + 1) % (1 << d)) == 0;
    end
    d = 2 * logW - lvl;
    return (col >= (1 << d)) && (((col + 1) % (1 << d)) == (1 << (d - 1)));
  endfunction

  // level that last wrote column col at or below level lvl (0 = per-bit stage)
  function automatic int srcLevel(input int lvl, input int col, input int logW);
    int src;
    src = 0;
    for (int l = 1; l <= lvl; l++)
      if (isCell(l, col, logW)) src = l;
    return src;
  endfunction

  // no later cell in this column: the cell is the column's carry node
  function automatic bit isFinal(input int lvl, input int col, input int logW);
    for (int l = lvl + 1; l <= levelCount(logW); l++)
      if (isCell(l, col, logW)) return 1'b0;
    return 1'b1;
  endfunction

  // values written at odd levels are true form; level 0 and even levels are complemented
  function automatic bit trueForm(input int lvl);
    return (lvl % 2) == 1;
  endfunction

endpackage

// File: rtl/pgInvGen.sv
module pgInvGen #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] genN,
  output logic [WIDTH-1:0] propN
);
  // active-low per-bit generate (NAND) and propagate (XNOR)
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign genN[i]  = ~(opA[i] & opB[i]);
    assign propN[i] = ~(opA[i] ^ opB[i]);
  end
endmodule

// File: rtl/fullCell.sv
module fullCell #(
  parameter bit ODD_LV = 1'b1
) (
  input  logic gHi,
  input  logic pHi,
  input  logic gLo,
  input  logic pLo,
  output logic gOut,
  output logic pOut
);
  if (ODD_LV) begin : gOdd
    // complemented in, true out
    assign gOut = ~(gHi & (pHi | gLo));
    assign pOut = ~(pHi | pLo);
  end else begin : gEven
    // true in, complemented out
    assign gOut = ~(gHi | (pHi & gLo));
    assign pOut = ~(pHi & pLo);
  end
endmodule

// File: rtl/reducedCell.sv
module reducedCell #(
  parameter bit ODD_LV = 1'b1
) (
  input  logic gHi,
  input  logic pHi,
  input  logic gLo,
  output logic gOut
);
  if (ODD_LV) begin : gOdd
    assign gOut = ~(gHi & (pHi | gLo));
  end else begin : gEven
    assign gOut = ~(gHi | (pHi & gLo));
  end
endmodule

// File: rtl/prefixNet.sv
module prefixNet
  import apAdderPkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] genN,
  input  logic [WIDTH-1:0] propN,
  output logic [WIDTH-1:0] carryRaw
);
  localparam int LOGW   = $clog2(WIDTH);
  localparam int LEVELS = levelCount(LOGW);

  logic [WIDTH-1:0] gLv [0:LEVELS];
  logic [WIDTH-1:0] pLv [0:LEVELS];

  assign gLv[0] = genN;
  assign pLv[0] = propN;

  for (genvar lv = 1; lv <= LEVELS; lv++) begin : gLevel
    for (genvar col = 0; col < WIDTH; col++) begin : gCol
      if (isCell(lv, col, LOGW)) begin : gNode
        localparam int  LO      = col - spanOf(lv, LOGW);
        localparam bit  WANT_T  = trueForm(lv - 1);
        // restoration where the source level has the cell's own parity
        localparam bit  HI_FLIP = trueForm(srcLevel(lv - 1, col, LOGW)) != WANT_T;
        localparam bit  LO_FLIP = trueForm(srcLevel(lv - 1, LO, LOGW)) != WANT_T;
        localparam bit  ODD     = trueForm(lv);
        logic gHi, pHi, gLo;
        assign gHi = gLv[lv-1][col] ^ HI_FLIP;
        assign pHi = pLv[lv-1][col] ^ HI_FLIP;
        assign gLo = gLv[lv-1][LO]  ^ LO_FLIP;
        if (isFinal(lv, col, LOGW)) begin : gRed
          reducedCell #(.ODD_LV(ODD)) uCell (
            .gHi(gHi), .pHi(pHi), .gLo(gLo), .gOut(gLv[lv][col])
          );
          // group propagate of a finished column is never read again
          assign pLv[lv][col] = pLv[lv-1][col];
        end else begin : gFull
          logic pLo;
          assign pLo = pLv[lv-1][LO] ^ LO_FLIP;
          fullCell #(.ODD_LV(ODD)) uCell (
            .gHi(gHi), .pHi(pHi), .gLo(gLo), .pLo(pLo),
            .gOut(gLv[lv][col]), .pOut(pLv[lv][col])
          );
        end
      end else begin : gPass
        assign gLv[lv][col] = gLv[lv-1][col];
        assign pLv[lv][col] = pLv[lv-1][col];
      end
    end
  end

  assign carryRaw = gLv[LEVELS];
endmodule

// File: rtl/sumForm.sv
module sumForm
  import apAdderPkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] propN,
  input  logic [WIDTH-1:0] carryRaw,
  output logic [WIDTH-1:0] sumOut,
  output logic [WIDTH-1:0] carryTrue
);
  localparam int LOGW   = $clog2(WIDTH);
  localparam int LEVELS = levelCount(LOGW);

  for (genvar col = 0; col < WIDTH; col++) begin : gCol
    localparam bit CT = trueForm(srcLevel(LEVELS, col, LOGW));
    assign carryTrue[col] = CT ? carryRaw[col] : ~carryRaw[col];
    if (col == 0) begin : gLsb
      assign sumOut[col] = ~propN[col];
    end else begin : gUp
      localparam bit PT = trueForm(srcLevel(LEVELS, col - 1, LOGW));
      if (PT) begin : gTrueC
        assign sumOut[col] = ~(propN[col] ^ carryRaw[col-1]);
      end else begin : gCompC
        assign sumOut[col] = propN[col] ^ carryRaw[col-1];
      end
    end
  end
endmodule

// File: rtl/apPrefixAdder.sv
module apPrefixAdder #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH-1:0] genN, propN, carryRaw, carryTrue;

  pgInvGen #(.WIDTH(WIDTH)) uPg (
    .opA(opA), .opB(opB), .genN(genN), .propN(propN)
  );

  prefixNet #(.WIDTH(WIDTH)) uNet (
    .genN(genN), .propN(propN), .carryRaw(carryRaw)
  );

  sumForm #(.WIDTH(WIDTH)) uSum (
    .propN(propN), .carryRaw(carryRaw), .sumOut(sumOut), .carryTrue(carryTrue)
  );

  assign carryOut = carryTrue[WIDTH-1];
endmodule

// File: rtl/apPrefixAdderChk.sv
module apPrefixAdderChk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic [WIDTH-1:0] carryTrue
);
  logic [WIDTH:0]   refSum;
  logic [WIDTH-1:0] rippleC;

  always_comb begin
    refSum = {1'b0, opA} + {1'b0, opB};
    rippleC[0] = opA[0] & opB[0];
    for (int k = 1; k < WIDTH; k++)
      rippleC[k] = (opA[k] & opB[k]) | ((opA[k] ^ opB[k]) & rippleC[k-1]);
    if (!$isunknown({opA, opB, sumOut, carryOut, carryTrue})) begin
      assert_sum_match_R1: assert ({carryOut, sumOut} == refSum);
      assert_bit0_R3: assert (sumOut[0] == (opA[0] ^ opB[0]));
      assert_carry_chain_R9: assert (carryTrue == rippleC);
      if (opA == ~opB) begin
        assert_complement_R6: assert (&sumOut && !carryOut);
      end
      if (opA == '0) begin
        assert_identity_R7: assert (sumOut == opB && !carryOut);
      end
    end
  end
endmodule

bind apPrefixAdder apPrefixAdderChk #(.WIDTH(WIDTH)) uChk (
  .opA(opA), .opB(opB), .sumOut(sumOut), .carryOut(carryOut), .carryTrue(carryTrue)
);

// File: tb/sim_apPrefixAdder.sv
`timescale 1ns/1ps
module sim_apPrefixAdder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] a64 = '0, b64 = '0, s64;
  logic        c64;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        c32;
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic        c4;

  apPrefixAdder #(.WIDTH(64)) u0 (.opA(a64), .opB(b64), .sumOut(s64), .carryOut(c64));
  apPrefixAdder #(.WIDTH(32)) u1 (.opA(a32), .opB(b32), .sumOut(s32), .carryOut(c32));
  apPrefixAdder #(.WIDTH(4))  u2 (.opA(a4),  .opB(b4),  .sumOut(s4),  .carryOut(c4));

  task automatic check64(input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [64:0] exp;
    @(posedge clk);
    a64 = a; b64 = b;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    checks++;
    if ({c64, s64} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h got sum=%h cout=%b expected sum=%h cout=%b",
               tag, a, b, s64, c64, exp[63:0], exp[64]);
    end
  endtask

  task automatic check32(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    a32 = a; b32 = b;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    checks++;
    if ({c32, s32} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h got sum=%h cout=%b expected sum=%h cout=%b",
               tag, a, b, s32, c32, exp[31:0], exp[32]);
    end
  endtask

  task automatic check4(input logic [3:0] a, input logic [3:0] b, input string tag);
    logic [4:0] exp;
    @(posedge clk);
    a4 = a; b4 = b;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    checks++;
    if ({c4, s4} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h got sum=%h cout=%b expected sum=%h cout=%b",
               tag, a, b, s4, c4, exp[3:0], exp[4]);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [63:0] ones, alt5, altA, r;
    ones = '1;
    alt5 = {16{4'h5}};
    altA = {16{4'hA}};

    // R2: zero inputs give zero sum and no carry-out
    @(negedge clk);
    checks++;
    if (s64 !== '0 || c64 !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle got sum=%h cout=%b expected sum=0 cout=0", s64, c64);
    end
    check64('0, '0, "R2_zero");

    // R4: full-length ripple
    check64(ones, 64'd1, "R4_ones_plus_one");
    check64(64'd1, ones, "R4_one_plus_ones");
    // R5
    check64(ones, ones, "R5_ones_plus_ones");
    // R10 alternating patterns
    check64(alt5, altA, "R10_alt_5A");
    check64(alt5, alt5, "R10_alt_55");
    check64(altA, altA, "R10_alt_AA");

    // R6 and R7
    for (int i = 0; i < 40; i++) begin
      r = rnd64();
      check64(r, ~r, "R6_complement");
      check64('0, r, "R7_identity");
    end

    // R9: walking generate and walking ripple
    for (int k = 0; k < 64; k++) begin
      check64(64'd1 << k, 64'd1 << k, "R9_walk_generate");
      check64((64'd1 << k) - 64'd1 + (64'd1 << k), 64'd1, "R9_walk_ripple");
    end

    // R3: bit 0 under all four low-bit combinations
    for (int i = 0; i < 4; i++) begin
      r = rnd64();
      check64({r[63:1], i[0]}, {r[62:0], i[1]}, "R3_bit0");
    end

    // R1: random operands
    for (int i = 0; i < 3000; i++)
      check64(rnd64(), rnd64(), "R1_random");

    // R8: 32-bit build
    check32('1, 32'd1, "R8_w32_ripple");
    check32({8{4'h5}}, {8{4'hA}}, "R8_w32_alt");
    check32('1, '1, "R8_w32_ones");
    for (int i = 0; i < 1000; i++)
      check32($urandom(), $urandom(), "R8_w32_random");

    // R8: 4-bit build, every operand pair
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        check4(x[3:0], y[3:0], "R8_w4_exhaustive");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule